// File: doc/BRIEF.md
# Serial-Entry Signed Adder/Subtractor with Single-Digit Display

This block is a small calculator datapath for a board that has only switches, LEDs and a seven-segment display. Each of two 4-bit operands is keyed in one bit at a time. A data switch supplies the bit. A per-operand clock switch pushes that bit into a shift register. A third clock switch asks for a result. All three clock switches are filtered by debouncers, and each debouncer turns one accepted press into a single one-cycle pulse.

A select input chooses addition or subtraction. Both operations use one adder: subtraction feeds the inverted second operand and a carry-in of one. The result is captured only when a compute pulse arrives, and the sum wraps modulo 16. The captured value drives a set of LEDs. It is also interpreted as a signed number and shown on the rightmost digit as a magnitude, with a separate minus light. Both operand registers are mirrored to LEDs so the entered values can be checked before computing.

Top module: `serial_addsub_display`

## Requirements
- R1: After reset both operand registers and the result register are 0, the digit shows 0 and the minus light is off.
- R2: A clock-switch level that stays high for fewer than HOLD_CYCLES consecutive system clocks is ignored, and the operand LEDs keep their value.
- R3: Each accepted press of the A shift switch shifts operand A exactly once: the data bit enters bit 3 and bits 3..1 move to bits 2..0. Entering bits v[0], v[1], v[2], v[3] in that order loads value v.
- R4: The B shift switch loads operand B in the same way, and operand A is not changed by it.
- R5: With sub_sel = 0, an accepted compute press loads (A + B) mod 16 into the result.
- R6: With sub_sel = 1, an accepted compute press loads (A - B) mod 16, formed as A + ~B + 1.
- R7: The result holds its value between compute presses, even when the operands or sub_sel change.
- R8: When result bit 3 is 1, the minus light is on and the digit shows 16 - result. The value 8 (signed -8) shows magnitude 8. Otherwise the minus light is off and the digit shows the result.
- R9: The digit enable output is always 1110 (active low, only the rightmost digit enabled).
- R10: seg_n is {g,f,e,d,c,b,a} and active low. The lit segments for 0..8 are hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F (active-high form).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_bit | input | 1 | Serial data switch |
| shift_a_sw | input | 1 | Raw clock switch for operand A |
| shift_b_sw | input | 1 | Raw clock switch for operand B |
| compute_sw | input | 1 | Raw compute trigger switch |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| led_a | output | 4 | Operand A mirror |
| led_b | output | 4 | Operand B mirror |
| led_result | output | 4 | Registered result |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| digit_en_n | output | 4 | Active-low digit enables |
| minus_on | output | 1 | Minus light, active high |

## Verification
A debouncer stuck in the wrong level, or one that pulses twice, shows on the operand LEDs one press later: a missing or repeated shift moves every later bit to the wrong place. A wrong carry-in or a missing inversion in the adder shows on led_result right after the next compute press. A result register that loads without a trigger shows as soon as an operand changes. Display errors show combinationally in the same cycle as the result, so a corrupt magnitude or sign is visible as soon as the bench samples.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    localparam int SEG_W   = 7;
    localparam int DIGITS  = 4;

    typedef struct packed {
        logic             minus;
        logic [SEG_W-1:0] seg_n;
    } disp_t;

    localparam logic [DIGITS-1:0] DIGIT_RIGHT_N = 4'b1110;

    // Active-high glyph for one hex nibble, bit order {g,f,e,d,c,b,a}.
    function automatic logic [SEG_W-1:0] glyph(input logic [3:0] v);
        case (v)
            4'h0: glyph = 7'h3F;
            4'h1: glyph = 7'h06;
            4'h2: glyph = 7'h5B;
            4'h3: glyph = 7'h4F;
            4'h4: glyph = 7'h66;
            4'h5: glyph = 7'h6D;
            4'h6: glyph = 7'h7D;
            4'h7: glyph = 7'h07;
            4'h8: glyph = 7'h7F;
            4'h9: glyph = 7'h6F;
            4'hA: glyph = 7'h77;
            4'hB: glyph = 7'h7C;
            4'hC: glyph = 7'h39;
            4'hD: glyph = 7'h5E;
            4'hE: glyph = 7'h79;
            default: glyph = 7'h71;
        endcase
    endfunction
endpackage

// File: rtl/sw_debounce.sv
module sw_debounce #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          level;
        logic          pulse;
        logic [CW-1:0] cnt;
    } db_t;

    db_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = raw;
        st_d.s2    = st_q.s1;
        st_d.pulse = 1'b0;
        if (st_q.s2 != st_q.level) begin
            if (st_q.cnt == CW'(HOLD_CYCLES - 1)) begin
                st_d.level = st_q.s2;
                st_d.cnt   = '0;
                st_d.pulse = st_q.s2;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign press = st_q.pulse;

    // R3: one accepted press yields a one-cycle pulse only
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);
    // R2: a pulse only follows the filtered level going high
    p_pulse_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.level) |-> press);
endmodule

// File: rtl/sipo_shift.sv
module sipo_shift #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             bit_in,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] val_q, val_d;

    always_comb begin
        val_d = val_q;
        if (shift) val_d = {bit_in, val_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;

    // R3: existing bits move down one place per shift
    p_shift_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> value[WIDTH-2:0] == $past(value[WIDTH-1:1]));
    // R3: the new bit lands at the top
    p_shift_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> value[WIDTH-1] == $past(bit_in));
    // R2: without a shift pulse the register holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(value));
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sub,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] res_q, res_d;
    logic [WIDTH-1:0] addend;

    always_comb begin
        addend = sub ? ~op_b : op_b;
        res_d  = res_q;
        if (load) res_d = WIDTH'(op_a + addend + WIDTH'(sub));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result = res_q;

    // R5: add mode wraps modulo 2^WIDTH
    p_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load && !sub |=> result == WIDTH'($past(op_a) + $past(op_b)));
    // R6: subtract mode wraps modulo 2^WIDTH
    p_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load && sub |=> result == WIDTH'($past(op_a) - $past(op_b)));
    // R7: result holds without a trigger
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(result));
endmodule

// File: rtl/signed_digit.sv
module signed_digit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    output disp_t            disp
);
    logic             neg;
    logic [WIDTH-1:0] mag;

    always_comb begin
        neg        = value[WIDTH-1];
        mag        = neg ? WIDTH'(~value + 1'b1) : value;
        disp.minus = neg;
        disp.seg_n = ~glyph(4'(mag));
    end
endmodule

// File: rtl/serial_addsub_display.sv
module serial_addsub_display
    import addsub_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int HOLD_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_bit,
    input  logic             shift_a_sw,
    input  logic             shift_b_sw,
    input  logic             compute_sw,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] led_a,
    output logic [WIDTH-1:0] led_b,
    output logic [WIDTH-1:0] led_result,
    output logic [6:0]       seg_n,
    output logic [3:0]       digit_en_n,
    output logic             minus_on
);
    localparam int NSW = 3;

    logic [NSW-1:0] raw_sw, pulses;
    logic [WIDTH-1:0] res;
    disp_t disp;

    assign raw_sw = {compute_sw, shift_b_sw, shift_a_sw};

    for (genvar i = 0; i < NSW; i++) begin : g_db
        sw_debounce #(.HOLD_CYCLES(HOLD_CYCLES)) u_db (
            .clk(clk), .rst_n(rst_n), .raw(raw_sw[i]), .press(pulses[i]));
    end

    sipo_shift #(.WIDTH(WIDTH)) u_opa (
        .clk(clk), .rst_n(rst_n), .shift(pulses[0]), .bit_in(data_bit), .value(led_a));
    sipo_shift #(.WIDTH(WIDTH)) u_opb (
        .clk(clk), .rst_n(rst_n), .shift(pulses[1]), .bit_in(data_bit), .value(led_b));

    addsub_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .load(pulses[2]), .sub(sub_sel),
        .op_a(led_a), .op_b(led_b), .result(res));

    signed_digit #(.WIDTH(WIDTH)) u_disp (.value(res), .disp(disp));

    assign led_result = res;
    assign seg_n      = disp.seg_n;
    assign minus_on   = disp.minus;
    assign digit_en_n = DIGIT_RIGHT_N;

    // R8: a lit minus never comes with a zero magnitude
    p_neg_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        minus_on |-> seg_n != 7'h40);
    // R8: sign light follows the result MSB
    p_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        minus_on == led_result[WIDTH-1]);
    // R4: a B shift never disturbs operand A
    p_b_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulses[1] && !pulses[0] |=> $stable(led_a));
endmodule

// File: tb/serial_addsub_display_test.sv
module serial_addsub_display_test;
    localparam int HOLD = 4;
    localparam int GAP  = HOLD + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_bit = 1'b0, shift_a_sw = 1'b0, shift_b_sw = 1'b0;
    logic compute_sw = 1'b0, sub_sel = 1'b0;
    logic [3:0] led_a, led_b, led_result, digit_en_n;
    logic [6:0] seg_n;
    logic minus_on;

    int checks = 0;
    int failures = 0;

    typedef struct { logic [3:0] res; logic minus; logic [6:0] seg; string tag; } exp_t;
    exp_t sb[$];
    event sample_ev;
    bit monitor_done = 0;

    always #5 clk = ~clk;

    serial_addsub_display #(.WIDTH(4), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .data_bit(data_bit),
        .shift_a_sw(shift_a_sw), .shift_b_sw(shift_b_sw), .compute_sw(compute_sw),
        .sub_sel(sub_sel), .led_a(led_a), .led_b(led_b), .led_result(led_result),
        .seg_n(seg_n), .digit_en_n(digit_en_n), .minus_on(minus_on));

    function automatic logic [6:0] seg_of(input int m);
        logic [6:0] hi;
        case (m)
            0: hi = 7'h3F; 1: hi = 7'h06; 2: hi = 7'h5B; 3: hi = 7'h4F;
            4: hi = 7'h66; 5: hi = 7'h6D; 6: hi = 7'h7D; 7: hi = 7'h07;
            default: hi = 7'h7F;
        endcase
        return ~hi;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // which: 0 = A shift, 1 = B shift, 2 = compute
    task automatic press(input int which, input int len);
        @(negedge clk);
        case (which)
            0: shift_a_sw = 1'b1;
            1: shift_b_sw = 1'b1;
            default: compute_sw = 1'b1;
        endcase
        wait_cycles(len);
        shift_a_sw = 1'b0; shift_b_sw = 1'b0; compute_sw = 1'b0;
        wait_cycles(GAP);
    endtask

    task automatic load_op(input int which, input logic [3:0] v);
        for (int i = 0; i < 4; i++) begin
            data_bit = v[i];
            press(which, GAP);
        end
    endtask

    task automatic run_op(input logic [3:0] a, input logic [3:0] b, input logic sub, input string tag);
        exp_t e;
        logic [3:0] r;
        load_op(0, a);
        load_op(1, b);
        sub_sel = sub;
        press(2, GAP);
        r = sub ? 4'(a - b) : 4'(a + b);
        e.res = r; e.minus = r[3];
        e.seg = seg_of(r[3] ? 16 - int'(r) : int'(r));
        e.tag = tag;
        sb.push_back(e);
        ->sample_ev;
        wait_cycles(1);
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " result"}, 32'(led_result), 32'(e.res));
                check("R8 minus", 32'(minus_on), 32'(e.minus));
                check("R10 segments", 32'(seg_n), 32'(e.seg));
            end
        end
    end

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(2);
        // R1 reset state
        check("R1 led_a", 32'(led_a), 0);
        check("R1 led_b", 32'(led_b), 0);
        check("R1 result", 32'(led_result), 0);
        check("R1 minus", 32'(minus_on), 0);
        check("R10 zero glyph", 32'(seg_n), 32'(seg_of(0)));
        check("R9 enables", 32'(digit_en_n), 32'hE);

        // R2: short glitch ignored
        data_bit = 1'b1;
        press(0, HOLD - 2);
        check("R2 glitch A", 32'(led_a), 0);
        press(2, HOLD - 2);
        check("R2 glitch compute", 32'(led_result), 0);

        // R3: bit-by-bit placement
        data_bit = 1'b1; press(0, GAP);
        check("R3 first shift", 32'(led_a), 32'h8);
        data_bit = 1'b0; press(0, GAP);
        check("R3 second shift", 32'(led_a), 32'h4);
        data_bit = 1'b1; press(0, GAP);
        check("R3 third shift", 32'(led_a), 32'hA);

        // R4: B loads, A untouched
        load_op(1, 4'd3);
        check("R4 led_b", 32'(led_b), 3);
        check("R4 A kept", 32'(led_a), 32'hA);

        run_op(4'd5, 4'd3, 1'b0, "R5 5+3");
        run_op(4'd5, 4'd3, 1'b1, "R6 5-3");
        run_op(4'd3, 4'd5, 1'b1, "R6 3-5");
        run_op(4'd7, 4'd7, 1'b0, "R5 7+7 wrap");
        run_op(4'd0, 4'd8, 1'b1, "R6 0-8");
        run_op(4'd9, 4'd9, 1'b0, "R5 9+9 wrap");
        run_op(4'd4, 4'd4, 1'b1, "R6 4-4");

        // R7: result holds while operands and mode change
        load_op(0, 4'd1);
        sub_sel = 1'b0;
        check("R7 hold", 32'(led_result), 0);
        check("R7 hold minus", 32'(minus_on), 0);
        check("R9 enables later", 32'(digit_en_n), 32'hE);

        wait_cycles(5);
        monitor_done = 1;
    end

    initial begin
        fork
            wait (monitor_done);
            begin
                wait_cycles(150000);
                failures++; checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule